// File: doc/BRIEF.md
# Sampling-Clock Delay Line Tuning Controller

This block is the control and status side of a receive sampling-clock delay line made of 12 programmable delay stages. Software uses a small register interface to set three things: the delay of each stage, which stage output drives the sampling clock, and a sampling-enable bit that turns the output clock off. A write to the stage-delay field starts a length measurement. On the first rising edge of the reference input clock after that write, the block takes a snapshot of the 12 tap states, stores it as a length vector and raises a done flag. Software then looks for the highest set bit of the vector to learn how many stages cover one clock period. It raises the delay and measures again until the line fits.

The delay stages are not part of this block. Their outputs reach it as a 12-bit tap-state input, and the stage delay goes back out as a 7-bit code. The reference clock is sampled in the bus clock domain. The output clock is a gated multiplexer over the tap inputs.

Top module: `dly_tune_ctrl`

## Requirements
- R1: After reset, every register reads zero (address 0 SEN bit 0, address 1 SEL bits 3:0, address 2 UNIT bits 6:0, address 3 status with done flag at bit 12 and length vector at bits 11:0), and `unit_o` is zero.
- R2: A write to address 0, 1 or 2 stores SEN, SEL or UNIT at the bit positions given in R1, and the stored value reads back. `unit_o` always equals the stored UNIT.
- R3: Any write to address 2 clears the done flag from the next cycle on and arms a measurement.
- R4: While a measurement is armed, the first bus clock edge at which `ref_clk_i` is sampled high, after being sampled low at the previous edge, copies `tap_i` into the length vector. From the next cycle on, the done flag reads 1 and the measurement is no longer armed.
- R5: The length vector keeps its previous value at all other times, including while a measurement is armed and the tap inputs change.
- R6: While SEN is 1, `clk_out` is 0 whatever the tap inputs are.
- R7: When the output is enabled and SEN is 0, `clk_out` equals `tap_i[SEL]`. A SEL value of 12 to 15 selects tap 11.
- R8: After reset, `clk_out` stays 0 until software writes address 0 with SEN equal to 0.
- R9: Writes to address 3 have no effect on the status value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| ref_clk_i | input | 1 | Reference clock whose period is measured |
| tap_i | input | 12 | Tap states from the delay stages |
| unit_o | output | 7 | Stage delay code to the delay stages |
| clk_out | output | 1 | Gated, phase-selected sampling clock |

## Verification
If the arm state is wrong, the status register shows it one cycle after a reference edge: the done flag either fails to rise, or it rises and the length vector changes without a request. If the stored vector is corrupted, the status read shows it in the cycle the corruption happens, even when the tap inputs are toggled while no capture is pending. If the gate or the phase select is wrong, `clk_out` shows it in the same cycle, so every SEL value from 0 to 15 is checked against both a one-hot tap pattern and its inverse.

// File: rtl/dly_tune_pkg.sv
package dly_tune_pkg;
    localparam int NTAP    = 12;
    localparam int UNIT_W  = 7;
    localparam int SEL_W   = 4;
    localparam int ADDR_W  = 2;
    localparam int DATA_W  = 16;
    localparam int DONE_BIT = NTAP;

    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] A_PHASE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_UNIT   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd3;

    typedef struct packed {
        logic              sen;
        logic              out_en;
        logic [SEL_W-1:0]  sel;
        logic [UNIT_W-1:0] unit;
        logic              armed;
        logic              done;
        logic [NTAP-1:0]   lng;
    } regs_t;
endpackage

// File: rtl/dly_ref_edge.sv
module dly_ref_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    output logic rise_o
);
    logic ref_d, ref_q;

    always_comb begin
        ref_d = ref_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b1;
        else        ref_q <= ref_d;
    end

    assign rise_o = ref_i & ~ref_q;
endmodule

// File: rtl/dly_reg_file.sv
module dly_reg_file
    import dly_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rise_i,
    input  logic [NTAP-1:0]   tap_i,
    output logic              sen_o,
    output logic              out_en_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic [UNIT_W-1:0] unit_o
);
    regs_t st_d, st_q;
    logic  unit_wr, capture;
    logic  unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:UNIT_W];
    assign unit_wr      = wr_en && (addr == A_UNIT);
    assign capture      = st_q.armed && rise_i && !unit_wr;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                A_CTRL: begin
                    st_d.sen    = wdata[0];
                    st_d.out_en = ~wdata[0];
                end
                A_PHASE: st_d.sel = wdata[SEL_W-1:0];
                A_UNIT: begin
                    st_d.unit  = wdata[UNIT_W-1:0];
                    st_d.armed = 1'b1;
                    st_d.done  = 1'b0;
                end
                default: ;
            endcase
        end
        if (capture) begin
            st_d.lng   = tap_i;
            st_d.done  = 1'b1;
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:   rdata[0]            = st_q.sen;
            A_PHASE:  rdata[SEL_W-1:0]    = st_q.sel;
            A_UNIT:   rdata[UNIT_W-1:0]   = st_q.unit;
            A_STATUS: begin
                rdata[NTAP-1:0] = st_q.lng;
                rdata[DONE_BIT] = st_q.done;
            end
            default: ;
        endcase
    end

    assign sen_o    = st_q.sen;
    assign out_en_o = st_q.out_en;
    assign sel_o    = st_q.sel;
    assign unit_o   = st_q.unit;

    p_unit_wr_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_UNIT) |=> (!st_q.done && st_q.armed));

    p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && rise_i && !(wr_en && addr == A_UNIT))
        |=> (st_q.done && !st_q.armed && st_q.lng == $past(tap_i)));

    p_lng_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.armed && rise_i) |=> $stable(st_q.lng));

    p_status_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_STATUS && !st_q.armed) |=> $stable(st_q.lng) && $stable(st_q.done));
endmodule

// File: rtl/dly_tap_mux.sv
module dly_tap_mux
    import dly_tune_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTAP-1:0]  tap_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sen_i,
    input  logic             en_i,
    output logic             clk_o
);
    localparam logic [SEL_W-1:0] TOP_TAP = SEL_W'(NTAP - 1);

    logic [SEL_W-1:0] idx;
    logic             picked;

    always_comb begin
        idx    = (sel_i > TOP_TAP) ? TOP_TAP : sel_i;
        picked = 1'b0;
        for (int i = 0; i < NTAP; i++) begin
            if (idx == SEL_W'(i)) picked = tap_i[i];
        end
        clk_o = picked & en_i & ~sen_i;
    end

    p_gate_sen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sen_i |-> !clk_o);

    p_sel_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !sen_i && sel_i > TOP_TAP) |-> (clk_o == tap_i[NTAP-1]));
endmodule

// File: rtl/dly_tune_ctrl.sv
module dly_tune_ctrl
    import dly_tune_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ref_clk_i,
    input  logic [NTAP-1:0]   tap_i,
    output logic [UNIT_W-1:0] unit_o,
    output logic              clk_out
);
    logic             rise, sen, out_en;
    logic [SEL_W-1:0] sel;

    dly_ref_edge u_edge (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_clk_i), .rise_o(rise)
    );

    dly_reg_file u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rise_i(rise), .tap_i(tap_i),
        .sen_o(sen), .out_en_o(out_en), .sel_o(sel), .unit_o(unit_o)
    );

    dly_tap_mux u_mux (
        .clk(clk), .rst_n(rst_n), .tap_i(tap_i), .sel_i(sel),
        .sen_i(sen), .en_i(out_en), .clk_o(clk_out)
    );

    p_out_off_after_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !clk_out);
endmodule

// File: tb/dly_tune_ctrl_tb.sv
module dly_tune_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ref_clk_i = 1'b0;
    logic [11:0] tap_i = '0;
    logic [6:0]  unit_o;
    logic        clk_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done_all = 0;

    always #10 clk = ~clk;

    dly_tune_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ref_clk_i(ref_clk_i), .tap_i(tap_i),
        .unit_o(unit_o), .clk_out(clk_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #2;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        tap_i = 12'hFFF;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset read", v, 0);
        end
        chk("R1 unit_o reset", unit_o, 0);
        #2 chk("R8 clk_out off after reset", clk_out, 0);
    endtask

    task automatic t_regs;
        logic [15:0] v;
        wr(2'd1, 16'hFFF5);
        rd(2'd1, v); chk("R2 SEL readback", v, 16'h0005);
        wr(2'd2, 16'hFF55);
        rd(2'd2, v); chk("R2 UNIT readback", v, 16'h0055);
        chk("R2 unit_o", unit_o, 7'h55);
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); chk("R2 SEN readback", v, 16'h0001);
    endtask

    task automatic t_gate;
        tap_i = 12'hFFF;
        wr(2'd0, 16'h0001);
        #2 chk("R6 SEN forces clk_out low", clk_out, 0);
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'h0003);
        #2 chk("R8 clk_out enabled after SEN=0 write", clk_out, 1);
        wr(2'd0, 16'h0001);
        #2 chk("R6 SEN re-gates clk_out", clk_out, 0);
        wr(2'd0, 16'h0000);
    endtask

    task automatic t_mux;
        for (int s = 0; s < 16; s++) begin
            int t;
            t = (s > 11) ? 11 : s;
            wr(2'd1, 16'(s));
            tap_i = 12'(1 << t);
            #2 chk($sformatf("R7 sel %0d one-hot", s), clk_out, 1);
            tap_i = ~12'(1 << t);
            #2 chk($sformatf("R7 sel %0d inverse", s), clk_out, 0);
        end
    endtask

    task automatic t_measure;
        logic [15:0] v;
        ref_clk_i = 1'b0;
        tap_i = 12'h0F3;
        wr(2'd2, 16'h0010);
        rd(2'd3, v); chk("R3 done cleared after UNIT write", v[12], 0);
        repeat (3) @(negedge clk);
        rd(2'd3, v); chk("R4 no capture without edge", v[12], 0);
        ref_clk_i = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk("R4 capture on first ref edge", v, 16'h10F3);
        tap_i = 12'hA5A;
        ref_clk_i = 1'b0;
        repeat (2) @(negedge clk);
        ref_clk_i = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk("R5 no recapture when not armed", v, 16'h10F3);
        ref_clk_i = 1'b0;
        wr(2'd2, 16'h0011);
        rd(2'd3, v); chk("R5 old length kept while armed", v, 16'h00F3);
        tap_i = 12'h3C0;
        @(negedge clk);
        rd(2'd3, v); chk("R5 tap change while armed ignored", v, 16'h00F3);
        ref_clk_i = 1'b1;
        @(negedge clk);
        rd(2'd3, v); chk("R4 second capture", v, 16'h13C0);
        ref_clk_i = 1'b0;
    endtask

    task automatic t_status_ro;
        logic [15:0] v;
        wr(2'd3, 16'h0000);
        rd(2'd3, v); chk("R9 status write ignored", v, 16'h13C0);
        wr(2'd3, 16'hFFFF);
        rd(2'd3, v); chk("R9 status write ignored ones", v, 16'h13C0);
    endtask

    task automatic finish_run;
        if (!done_all) begin
            done_all = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gate();
        t_mux();
        t_measure();
        t_status_ro();
        finish_run();
    end
endmodule